// File: doc/BRIEF.md
# Two-Bank Interrupt Steering Controller

This block collects forty level-sensitive interrupt sources and spreads them over two 32-bit banks. Sources 0 to 31 occupy bank 0 and sources 32 to 39 occupy bank 1. For every source it keeps an enable bit and a routing bit. The routing bit sends the source either to the fast interrupt line of the processor or to its normal interrupt line.

While the core is halted, the block also raises a wake request. An idle-override control can let sources that are pending but disabled wake the core as well.

Software reaches the block over a single-cycle 32-bit register bus. Through it, software sets enables, routing, the override control and forty priority slots. It can also read filtered views of the pending state. The highest-priority word comes from a separate resolver on an input port and is only returned by a read here.

Top module: `irq_steer_ctrl`

## Requirements
- R1: Source n maps to bank n/32 at bit n%32. The bank-1 registers sit at 0x9C (normal view), 0xA0 (enable), 0xA4 (routing), 0xA8 (fast view) and 0xAC (raw). Bits 8 to 31 of the bank-1 registers always read zero.
- R2: The raw pending registers (0x10 for bank 0, 0xAC for bank 1) return the source levels captured at the previous clock edge. A source that drops clears its pending bit, because nothing is latched.
- R3: `fiq_o` is registered. After an edge it is high exactly when some source that is pending, enabled and routed (routing bit 1) exists in the state taken at that edge.
- R4: `irq_o` is registered. After an edge it is high exactly when some source that is pending, enabled and not routed (routing bit 0) exists in the state taken at that edge.
- R5: `wake_o` is registered. It is high after an edge only if `core_halted` was high at that edge and some pending source was enabled or covered by the idle override. The override is active while control bit 0 holds 0.
- R6: The normal view (0x00 / 0x9C) returns pending AND enable AND NOT routing. The fast view (0x0C / 0xA8) returns pending AND enable AND routing.
- R7: The enable registers (0x04 / 0xA0) and routing registers (0x08 / 0xA4) take a write at the clock edge and read back the stored implemented bits.
- R8: The control register (0x14) stores only bit 0 of a write. It reads 1 when that bit is 1 (override off) and 0 when it is 0.
- R9: Priority slot i is at 0x1C+4i for i<32 and at 0xB0+4(i-32) for i of 32 or more. A write keeps only bit 31 and bits 5:0 (mask 0x8000003F).
- R10: Offset 0x18 returns the `hp_word` input, and writes to it have no effect.
- R11: Reads of any other offset, including unaligned ones, return zero. Writes to unknown offsets and to the read-only offsets (0x00, 0x0C, 0x10, 0x18, 0x9C, 0xA8, 0xAC) change nothing.
- R12: Reset clears pending, enable and routing in both banks and clears all priority slots. It leaves the override inactive, so control reads 1, and drives all three outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NUM_SRC | Interrupt source levels |
| core_halted | input | 1 | Core is halted and may be woken |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset, same cycle |
| hp_word | input | 32 | Highest-priority word from the external resolver |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request for a halted core |

## Verification
Several rules are checked on every cycle:
- The wake line never rises without a halt in the previous cycle.
- Raw bank-0 pending matches the previous cycle's levels.
- A quiet fast or normal line implies an all-zero view for that line.
- All sources low leaves every output low.
- Unknown offsets read zero, and the unused bits of the control and priority words read zero.

The exact masking of priority writes, the bank-1 bit placement, the override polarity, read-only writes changing nothing, and the return to reset values after a mid-run reset can only be shown by the bench. It does this with targeted writes and reads plus a randomized phase that is compared against a behavioural model.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int BANK_W = 32;
    localparam int SLOT_W = 6;

    typedef enum logic [3:0] {
        REG_NONE, REG_IRQV, REG_MASK, REG_STEER, REG_FIQV,
        REG_RAW, REG_CTRL, REG_HP, REG_PRIO
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic              bank;
        logic [SLOT_W-1:0] slot;
    } reg_sel_t;

    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] idx;
    } prio_slot_t;

    function automatic reg_sel_t decode_ofs(input logic [ADDR_W-1:0] ofs);
        reg_sel_t          s;
        logic [ADDR_W-1:0] rel;
        s = '{kind: REG_NONE, bank: 1'b0, slot: '0};
        rel = '0;
        case (ofs)
            8'h00: s.kind = REG_IRQV;
            8'h04: s.kind = REG_MASK;
            8'h08: s.kind = REG_STEER;
            8'h0C: s.kind = REG_FIQV;
            8'h10: s.kind = REG_RAW;
            8'h14: s.kind = REG_CTRL;
            8'h18: s.kind = REG_HP;
            8'h9C: s = '{kind: REG_IRQV,  bank: 1'b1, slot: '0};
            8'hA0: s = '{kind: REG_MASK,  bank: 1'b1, slot: '0};
            8'hA4: s = '{kind: REG_STEER, bank: 1'b1, slot: '0};
            8'hA8: s = '{kind: REG_FIQV,  bank: 1'b1, slot: '0};
            8'hAC: s = '{kind: REG_RAW,   bank: 1'b1, slot: '0};
            default: begin
                if (ofs[1:0] == 2'b00 && ofs >= 8'h1C && ofs <= 8'h98) begin
                    rel    = ofs - 8'h1C;
                    s.kind = REG_PRIO;
                    s.slot = SLOT_W'(rel[ADDR_W-1:2]);
                end else if (ofs[1:0] == 2'b00 && ofs >= 8'hB0 && ofs <= 8'hCC) begin
                    rel    = ofs - 8'hB0;
                    s.kind = REG_PRIO;
                    s.slot = SLOT_W'(32) + SLOT_W'(rel[ADDR_W-1:2]);
                end
            end
        endcase
        return s;
    endfunction
endpackage

// File: rtl/irqs_bank.sv
module irqs_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic         mask_we_i,
    input  logic         steer_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         idle_ovr_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] steer_o,
    output logic         fiq_hit_o,
    output logic         irq_hit_o,
    output logic         wake_hit_o
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] mask;
        logic [W-1:0] steer;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = lvl_i;
        if (mask_we_i)  st_d.mask  = wdata_i;
        if (steer_we_i) st_d.steer = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o     = st_q.pend;
    assign mask_o     = st_q.mask;
    assign steer_o    = st_q.steer;
    // hit flags use next-state so the registered outputs line up with the state
    assign fiq_hit_o  = |(st_d.pend & st_d.mask & st_d.steer);
    assign irq_hit_o  = |(st_d.pend & st_d.mask & ~st_d.steer);
    assign wake_hit_o = |(st_d.pend & (st_d.mask | {W{idle_ovr_i}}));
endmodule

// File: rtl/irqs_prio_file.sv
module irqs_prio_file import irqs_pkg::*; #(
    parameter int N = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SLOT_W-1:0] ridx_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - 1 - SLOT_W;

    prio_slot_t slot_d [N];
    prio_slot_t slot_q [N];

    always_comb begin
        slot_d = slot_q;
        for (int i = 0; i < N; i++) begin
            if (we_i && widx_i == SLOT_W'(i)) begin
                slot_d[i].en  = wdata_i[DATA_W-1];
                slot_d[i].idx = wdata_i[SLOT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) slot_q[i] <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N; i++) begin
            if (ridx_i == SLOT_W'(i))
                rdata_o = {slot_q[i].en, {PAD_W{1'b0}}, slot_q[i].idx};
        end
    end
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl import irqs_pkg::*; #(
    parameter int NUM_SRC = 40   // 33..64 sources, two banks
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic               core_halted,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  hp_word,
    output logic               fiq_o,
    output logic               irq_o,
    output logic               wake_o
);
    localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;

    typedef struct packed {
        logic ovr_off;
        logic fiq;
        logic irq;
        logic wake;
    } top_st_t;

    top_st_t  st_d, st_q;
    reg_sel_t sel;
    logic     slot_ok, ctrl_we, prio_we, idle_ovr_d;
    logic [DATA_W-1:0]    prio_rd;
    logic [NUM_BANKS-1:0] mask_we, steer_we, fiq_hit, irq_hit, wake_hit;
    logic [BANK_W-1:0]    pend_b  [NUM_BANKS];
    logic [BANK_W-1:0]    mask_b  [NUM_BANKS];
    logic [BANK_W-1:0]    steer_b [NUM_BANKS];

    assign sel        = decode_ofs(bus_addr);
    assign slot_ok    = int'(sel.slot) < NUM_SRC;
    assign ctrl_we    = bus_wr && sel.kind == REG_CTRL;
    assign prio_we    = bus_wr && sel.kind == REG_PRIO && slot_ok;
    assign idle_ovr_d = ctrl_we ? ~bus_wdata[0] : ~st_q.ovr_off;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BW = (NUM_SRC - b*BANK_W > BANK_W) ? BANK_W : NUM_SRC - b*BANK_W;
        logic [BW-1:0] pend, mask, steer;

        assign mask_we[b]  = bus_wr && sel.kind == REG_MASK  && int'(sel.bank) == b;
        assign steer_we[b] = bus_wr && sel.kind == REG_STEER && int'(sel.bank) == b;

        irqs_bank #(.W(BW)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl_i      (src_lvl[b*BANK_W +: BW]),
            .mask_we_i  (mask_we[b]),
            .steer_we_i (steer_we[b]),
            .wdata_i    (bus_wdata[BW-1:0]),
            .idle_ovr_i (idle_ovr_d),
            .pend_o     (pend),
            .mask_o     (mask),
            .steer_o    (steer),
            .fiq_hit_o  (fiq_hit[b]),
            .irq_hit_o  (irq_hit[b]),
            .wake_hit_o (wake_hit[b])
        );

        assign pend_b[b]  = BANK_W'(pend);
        assign mask_b[b]  = BANK_W'(mask);
        assign steer_b[b] = BANK_W'(steer);
    end

    irqs_prio_file #(.N(NUM_SRC)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (prio_we),
        .widx_i  (sel.slot),
        .wdata_i (bus_wdata),
        .ridx_i  (sel.slot),
        .rdata_o (prio_rd)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ovr_off = ~idle_ovr_d;
        st_d.fiq     = |fiq_hit;
        st_d.irq     = |irq_hit;
        st_d.wake    = core_halted & (|wake_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ovr_off: 1'b1, fiq: 1'b0, irq: 1'b0, wake: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            REG_IRQV:  bus_rdata = pend_b[sel.bank] & mask_b[sel.bank] & ~steer_b[sel.bank];
            REG_FIQV:  bus_rdata = pend_b[sel.bank] & mask_b[sel.bank] & steer_b[sel.bank];
            REG_MASK:  bus_rdata = mask_b[sel.bank];
            REG_STEER: bus_rdata = steer_b[sel.bank];
            REG_RAW:   bus_rdata = pend_b[sel.bank];
            REG_CTRL:  bus_rdata = DATA_W'(st_q.ovr_off);
            REG_HP:    bus_rdata = hp_word;
            REG_PRIO:  bus_rdata = slot_ok ? prio_rd : '0;
            default:   bus_rdata = '0;
        endcase
    end

    assign fiq_o  = st_q.fiq;
    assign irq_o  = st_q.irq;
    assign wake_o = st_q.wake;
endmodule

// File: rtl/irqs_chk.sv
module irqs_chk #(
    parameter int NUM_SRC = 40
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_lvl,
    input logic               core_halted,
    input logic [7:0]         bus_addr,
    input logic [31:0]        bus_rdata,
    input logic               fiq_o,
    input logic               irq_o,
    input logic               wake_o
);
    // R5
    wake_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(core_halted));

    // R2
    raw_tracks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && bus_addr == 8'h10) |-> bus_rdata == $past(src_lvl[31:0]));

    // R3
    fiq_quiet_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fiq_o && (bus_addr == 8'h0C || bus_addr == 8'hA8)) |-> bus_rdata == 32'h0);

    // R4
    irq_quiet_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && (bus_addr == 8'h00 || bus_addr == 8'h9C)) |-> bus_rdata == 32'h0);

    // R12 (outputs quiet with no source, also R3 and R4)
    no_source_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_lvl) == '0) |-> (!fiq_o && !irq_o && !wake_o));

    // R11
    unknown_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > 8'hCC || bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'h0);

    // R8
    ctrl_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h14) |-> bus_rdata[31:1] == 31'h0);

    // R9
    prio_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] == 2'b00 && ((bus_addr >= 8'h1C && bus_addr <= 8'h98) ||
         (bus_addr >= 8'hB0 && bus_addr <= 8'hCC))) |-> bus_rdata[30:6] == 25'h0);
endmodule

bind irq_steer_ctrl irqs_chk #(.NUM_SRC(NUM_SRC)) i_irqs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_lvl     (src_lvl),
    .core_halted (core_halted),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .fiq_o       (fiq_o),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
);

// File: tb/test_irq_steer_ctrl.sv
`timescale 1ns/1ps
module test_irq_steer_ctrl;
    localparam int NSRC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic        halted = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] hp = 32'h8005_001F;
    logic [31:0] rdata;
    logic        fiq, irq, wake;

    int n_chk = 0;
    int n_fail = 0;
    bit running = 1'b0;

    always #2 clk = ~clk;

    irq_steer_ctrl #(.NUM_SRC(NSRC)) i_irq_steer_ctrl (
        .clk(clk), .rst_n(rst_n), .src_lvl(src), .core_halted(halted),
        .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
        .hp_word(hp), .fiq_o(fiq), .irq_o(irq), .wake_o(wake)
    );

    // ---------------- behavioural reference model ----------------
    logic [NSRC-1:0] m_pend, m_mask, m_steer;
    logic            m_ovr_off;
    logic [31:0]     m_prio [NSRC];
    logic            m_fiq, m_irq, m_wake;

    function automatic int prio_slot_of(input logic [7:0] a);
        int v = int'(a);
        if (v % 4 != 0) return -1;
        if (v >= 28 && v <= 152) return (v - 28) / 4;
        if (v >= 176 && v <= 204) return 32 + (v - 176) / 4;
        return -1;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int s = prio_slot_of(a);
        if      (a == 8'h04) m_mask[31:0]   = d;
        else if (a == 8'hA0) m_mask[39:32]  = d[7:0];
        else if (a == 8'h08) m_steer[31:0]  = d;
        else if (a == 8'hA4) m_steer[39:32] = d[7:0];
        else if (a == 8'h14) m_ovr_off      = d[0];
        else if (s >= 0)     m_prio[s]      = d & 32'h8000_003F;
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [63:0] p, m, st;
        int s = prio_slot_of(a);
        p  = 64'(m_pend);
        m  = 64'(m_mask);
        st = 64'(m_steer);
        case (a)
            8'h00: return p[31:0] & m[31:0] & ~st[31:0];
            8'h04: return m[31:0];
            8'h08: return st[31:0];
            8'h0C: return p[31:0] & m[31:0] & st[31:0];
            8'h10: return p[31:0];
            8'h14: return {31'h0, m_ovr_off};
            8'h18: return hp;
            8'h9C: return p[63:32] & m[63:32] & ~st[63:32];
            8'hA0: return m[63:32];
            8'hA4: return st[63:32];
            8'hA8: return p[63:32] & m[63:32] & st[63:32];
            8'hAC: return p[63:32];
            default: return (s >= 0) ? m_prio[s] : 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_mask = '0; m_steer = '0; m_ovr_off = 1'b1;
            for (int i = 0; i < NSRC; i++) m_prio[i] = '0;
            m_fiq = 1'b0; m_irq = 1'b0; m_wake = 1'b0;
        end else begin
            if (wr) model_write(addr, wdata);
            m_pend = src;
            m_fiq  = |(m_pend & m_mask & m_steer);
            m_irq  = |(m_pend & m_mask & ~m_steer);
            m_wake = halted && |(m_pend & (m_mask | (m_ovr_off ? '0 : {NSRC{1'b1}})));
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison of the interrupt lines
    always @(negedge clk) begin
        if (running && rst_n) begin
            chk("R3 fiq line", 32'(fiq), 32'(m_fiq));
            chk("R4 irq line", 32'(irq), 32'(m_irq));
            chk("R5 wake line", 32'(wake), 32'(m_wake));
        end
    end

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); addr = a; wr = 1'b0;
        #1 chk(tag, rdata, exp);
    endtask

    task automatic rd_mdl(input logic [7:0] a, input string tag);
        @(negedge clk); addr = a; wr = 1'b0;
        #1 chk(tag, rdata, model_read(a));
    endtask

    task automatic set_src(input logic [NSRC-1:0] v);
        @(negedge clk); src = v;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] wa [5];
        wa[0] = 8'h04; wa[1] = 8'h08; wa[2] = 8'hA0; wa[3] = 8'hA4; wa[4] = 8'h14;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        // R12 reset state
        rd_exp(8'h14, 32'h1, "R12 ctrl after reset");
        rd_exp(8'h04, 32'h0, "R12 mask0 after reset");
        rd_exp(8'hA4, 32'h0, "R12 steer1 after reset");
        rd_exp(8'h1C, 32'h0, "R12 slot0 after reset");
        rd_exp(8'hCC, 32'h0, "R12 slot39 after reset");
        chk("R12 outputs low", {29'h0, fiq, irq, wake}, 32'h0);

        // R2 raw pending, disabled sources give no line
        set_src(40'h00_8000_0003);
        rd_exp(8'h10, 32'h8000_0003, "R2 raw bank0");
        rd_exp(8'h00, 32'h0, "R6 view with mask clear");
        chk("R4 irq low while masked", 32'(irq), 32'h0);

        // R7 enable, R4 normal line, R6 view
        do_wr(8'h04, 32'h8000_0001);
        chk("R4 irq after enable", 32'(irq), 32'h1);
        rd_exp(8'h04, 32'h8000_0001, "R7 mask0 readback");
        rd_exp(8'h00, 32'h8000_0001, "R6 normal view");

        // R3 routing source 0 to the fast line
        do_wr(8'h08, 32'h0000_0001);
        chk("R3 fiq after routing", 32'(fiq), 32'h1);
        chk("R4 irq still from src31", 32'(irq), 32'h1);
        rd_exp(8'h0C, 32'h1, "R6 fast view");
        rd_exp(8'h00, 32'h8000_0000, "R6 normal view excludes routed");
        rd_exp(8'h08, 32'h1, "R7 steer0 readback");
        set_src(40'h1);
        chk("R4 irq drops with src31", 32'(irq), 32'h0);
        set_src(40'h0);
        chk("R3 fiq drops, no latch", 32'(fiq), 32'h0);
        rd_exp(8'h10, 32'h0, "R2 pending cleared");

        // R1 bank 1
        set_src(40'h08_0000_0000);
        rd_exp(8'hAC, 32'h8, "R1 src35 at bank1 bit3");
        rd_exp(8'h10, 32'h0, "R1 bank0 untouched");
        do_wr(8'hA0, 32'hFFFF_FFFF);
        rd_exp(8'hA0, 32'hFF, "R1 bank1 mask upper bits zero");
        chk("R4 irq from bank1", 32'(irq), 32'h1);
        rd_exp(8'h9C, 32'h8, "R6 bank1 normal view");
        do_wr(8'hA4, 32'h8);
        chk("R3 fiq from bank1", 32'(fiq), 32'h1);
        chk("R4 irq off after routing", 32'(irq), 32'h0);
        rd_exp(8'hA8, 32'h8, "R6 bank1 fast view");
        rd_exp(8'hA4, 32'h8, "R7 steer1 readback");

        // R5 / R8 wake and override
        set_src(40'h100);
        @(negedge clk); halted = 1'b1;
        @(negedge clk);
        chk("R5 no wake for masked src, override off", 32'(wake), 32'h0);
        do_wr(8'h14, 32'h2);
        chk("R5 wake with override on", 32'(wake), 32'h1);
        rd_exp(8'h14, 32'h0, "R8 ctrl reads 0");
        @(negedge clk); halted = 1'b0;
        @(negedge clk);
        chk("R5 wake needs halt", 32'(wake), 32'h0);
        do_wr(8'h14, 32'hFFFF_FFFF);
        rd_exp(8'h14, 32'h1, "R8 ctrl reads 1");

        // R9 priority slots
        do_wr(8'h1C, 32'hFFFF_FFFF);
        rd_exp(8'h1C, 32'h8000_003F, "R9 slot0 masked");
        do_wr(8'hCC, 32'h1234_5667);
        rd_exp(8'hCC, 32'h0000_0027, "R9 slot39 masked");
        do_wr(8'h98, 32'h8000_0027);
        rd_exp(8'h98, 32'h8000_0027, "R9 slot31");
        rd_exp(8'hB0, 32'h0, "R9 slot32 untouched");
        rd_exp(8'h20, 32'h0, "R9 slot1 untouched");

        // R10 resolver word
        rd_exp(8'h18, 32'h8005_001F, "R10 hp read");
        do_wr(8'h18, 32'h0);
        rd_exp(8'h18, 32'h8005_001F, "R10 hp write ignored");
        hp = 32'h003F_003F;
        rd_exp(8'h18, 32'h003F_003F, "R10 hp follows input");

        // R11 unknown and read-only offsets
        rd_exp(8'hD0, 32'h0, "R11 unknown D0");
        rd_exp(8'hFC, 32'h0, "R11 unknown FC");
        rd_exp(8'h1E, 32'h0, "R11 unaligned");
        do_wr(8'h10, 32'hFFFF_FFFF);
        rd_exp(8'h10, 32'h100, "R11 raw write ignored");
        do_wr(8'h00, 32'hFFFF_FFFF);
        rd_exp(8'h04, 32'h8000_0001, "R11 view write ignored");
        do_wr(8'hA8, 32'hFFFF_FFFF);
        rd_exp(8'hA4, 32'h8, "R11 bank1 view write ignored");
        do_wr(8'hE0, 32'hFFFF_FFFF);
        rd_exp(8'h08, 32'h1, "R11 unknown write ignored");

        // randomized phase against the model
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            src    = {$urandom, $urandom} & {NSRC{1'b1}};
            if ($urandom % 3 == 0) src = '0;
            halted = $urandom % 2;
            if ($urandom % 3 == 0) begin
                addr = wa[$urandom % 5]; wdata = $urandom; wr = 1'b1;
            end else begin
                addr = 8'($urandom % 8'hD4); wr = 1'b0;
                #1 chk("R6 random read", rdata, model_read(addr));
            end
        end
        @(negedge clk); wr = 1'b0;
        rd_mdl(8'h00, "R6 view after random");
        rd_mdl(8'hA8, "R6 bank1 view after random");

        // R12 mid-run reset
        do_wr(8'h1C, 32'h8000_0005);
        do_reset();
        rd_exp(8'h04, 32'h0, "R12 mask0 cleared");
        rd_exp(8'h08, 32'h0, "R12 steer0 cleared");
        rd_exp(8'hA0, 32'h0, "R12 mask1 cleared");
        rd_exp(8'h14, 32'h1, "R12 ctrl back to 1");
        rd_exp(8'h1C, 32'h0, "R12 slot0 cleared");

        running = 1'b0;
        finish_run();
    end
endmodule